// File: doc/BRIEF.md
# Shared-Bus Priority Arbitration Controller

This block handles bus acquisition for one device on a shared, wired-OR parallel peripheral bus. When a start request arrives, it waits until it has seen BSY and SEL both released for long enough. It then arbitrates by driving BSY together with the data line that matches its own ID. At the end of the arbitration window it reads back the data lines. If no higher ID is present, it has won.

The winner releases BSY and asserts SEL. It drives its own ID bit and the target's ID bit on the data lines, and drives I/O to choose between plain selection (I/O low) and reselection (I/O high). It then waits for the addressed device to answer with BSY. The result is reported as a one-cycle flag: won, lost, selected or timeout.

The minimum delays are computed from a clock-period parameter and rounded up to whole cycles. At the default 4 ns clock this gives:

- an entry wait of 300 cycles (1.2 µs),
- an arbitration hold of 600 cycles (2.4 µs),
- a response window of 50000 cycles (200 µs).

A bus reset throws the controller back to rest at once.

Top module: `busarb_ctrl`

## Requirements
- R1: After the synchronous reset, every drive enable (BSY, SEL, I/O, all data lines) and all four result flags are low.
- R2: After a start request, the controller asserts drives only after sampling BSY and SEL both low on 300 consecutive clock edges. Any sample with either line high restarts that count.
- R3: During arbitration the controller drives BSY plus exactly the data line of its own ID (bit `own_id_i`) for 600 cycles, with SEL and I/O low.
- R4: At the end of arbitration, a sampled data bit above the own ID causes a one-cycle `lost_o` pulse and releases all drives. Otherwise a one-cycle `won_o` pulse is raised. At most one result flag is high in any cycle.
- R5: From the cycle after winning, the controller releases BSY, asserts SEL, drives the data lines at bit positions own ID and target ID, and drives I/O equal to `resel_i` as captured with the start request.
- R6: A BSY sampled high while waiting for a response raises a one-cycle `selected_o` pulse and releases all drives on the next cycle.
- R7: Without a response within 50000 cycles of entering selection, a one-cycle `timeout_o` pulse is raised and all drives are released. A response sampled on the final window cycle counts as selected and never as a timeout.
- R8: While `bus_rst_i` is high, the controller returns to rest on the next cycle: all drives are released, no flag is raised, a pending request is dropped, and `start_i` is ignored.
- R9: The data bus is `DATA_W` lines wide and IDs run from 0 to `DATA_W`-1. The highest ID (7 at the default width) wins against any lower contender.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_bsy_i | input | 1 | Sampled BSY line (wired-OR of all devices) |
| bus_sel_i | input | 1 | Sampled SEL line |
| bus_rst_i | input | 1 | Sampled bus reset line |
| bus_data_i | input | DATA_W | Sampled data lines |
| own_id_i | input | ID_W | This device's ID |
| tgt_id_i | input | ID_W | ID of the device to select or reselect |
| resel_i | input | 1 | 1 = reselection (I/O asserted), 0 = selection |
| start_i | input | 1 | Request to acquire the bus |
| drv_bsy_o | output | 1 | Drive enable for BSY |
| drv_sel_o | output | 1 | Drive enable for SEL |
| drv_io_o | output | 1 | Drive enable for I/O |
| drv_data_o | output | DATA_W | Drive enables for the data lines |
| won_o | output | 1 | Pulse: arbitration won |
| lost_o | output | 1 | Pulse: arbitration lost |
| selected_o | output | 1 | Pulse: peer answered with BSY |
| timeout_o | output | 1 | Pulse: no answer within the window |

## Verification
Two decisions can fall in the same cycle.

The first is the peer's BSY response arriving on the last cycle of the response window. The bench raises the peer's BSY exactly 49999 cycles after selection begins and expects a lone `selected_o` at the window's end, with no `timeout_o`.

The second is a bus reset that coincides with the peer's response. The bench asserts both on the same edge and requires the drives to drop with no result flag at all. Any flag that the scoreboard did not predict counts as a failure.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    typedef enum logic [1:0] {
        ST_REST  = 2'd0,
        ST_ENTRY = 2'd1,
        ST_ARB   = 2'd2,
        ST_SEL   = 2'd3
    } arb_state_e;

    typedef struct packed {
        logic timeout;
        logic selected;
        logic lost;
        logic won;
    } arb_flags_t;

    // Whole cycles covering a delay in ns, rounded up
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/busarb_cnt.sv
module busarb_cnt #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (en) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/busarb_prio.sv
module busarb_prio #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ID_W   = 3
) (
    input  logic [DATA_W-1:0] data,
    input  logic [ID_W-1:0]   own_id,
    output logic              higher_seen
);
    logic [DATA_W-1:0] above_mask;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign above_mask[i] = (own_id < ID_W'(i));
    end

    assign higher_seen = |(data & above_mask);
endmodule

// File: rtl/busarb_drive.sv
module busarb_drive
    import busarb_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ID_W   = 3
) (
    input  arb_state_e        st,
    input  logic [ID_W-1:0]   own_id,
    input  logic [ID_W-1:0]   tgt_id,
    input  logic              resel,
    output logic              drv_bsy,
    output logic              drv_sel,
    output logic              drv_io,
    output logic [DATA_W-1:0] drv_data
);
    logic [DATA_W-1:0] own_bit;
    logic [DATA_W-1:0] tgt_bit;

    for (genvar i = 0; i < DATA_W; i++) begin : g_dec
        assign own_bit[i] = (own_id == ID_W'(i));
        assign tgt_bit[i] = (tgt_id == ID_W'(i));
    end

    always_comb begin
        drv_bsy  = 1'b0;
        drv_sel  = 1'b0;
        drv_io   = 1'b0;
        drv_data = '0;
        case (st)
            ST_ARB: begin
                drv_bsy  = 1'b1;
                drv_data = own_bit;
            end
            ST_SEL: begin
                drv_sel  = 1'b1;
                drv_io   = resel;
                drv_data = own_bit | tgt_bit;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/busarb_ctrl.sv
module busarb_ctrl
    import busarb_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CLK_PS    = 4000,
    parameter int unsigned SETTLE_NS = 400,
    parameter int unsigned FREE_NS   = 800,
    parameter int unsigned ARB_NS    = 2400,
    parameter int unsigned RESP_NS   = 200000,
    localparam int unsigned ID_W     = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_bsy_i,
    input  logic              bus_sel_i,
    input  logic              bus_rst_i,
    input  logic [DATA_W-1:0] bus_data_i,
    input  logic [ID_W-1:0]   own_id_i,
    input  logic [ID_W-1:0]   tgt_id_i,
    input  logic              resel_i,
    input  logic              start_i,
    output logic              drv_bsy_o,
    output logic              drv_sel_o,
    output logic              drv_io_o,
    output logic [DATA_W-1:0] drv_data_o,
    output logic              won_o,
    output logic              lost_o,
    output logic              selected_o,
    output logic              timeout_o
);
    localparam int unsigned ENTRY_CYC = ns_to_cycles(SETTLE_NS, CLK_PS)
                                      + ns_to_cycles(FREE_NS, CLK_PS);
    localparam int unsigned ARB_CYC   = ns_to_cycles(ARB_NS, CLK_PS);
    localparam int unsigned RESP_CYC  = ns_to_cycles(RESP_NS, CLK_PS);
    localparam int unsigned MAX_CYC   = max3(ENTRY_CYC, ARB_CYC, RESP_CYC);
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] ENTRY_LAST = CNT_W'(ENTRY_CYC - 1);
    localparam logic [CNT_W-1:0] ARB_LAST   = CNT_W'(ARB_CYC - 1);
    localparam logic [CNT_W-1:0] RESP_LAST  = CNT_W'(RESP_CYC - 1);

    arb_state_e       st_q, st_d;
    arb_flags_t       flg_q, flg_d;
    logic [ID_W-1:0]  tgt_q;
    logic             resel_q;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             higher_seen;
    logic             bus_quiet;

    assign bus_quiet = !bus_bsy_i && !bus_sel_i;

    busarb_cnt #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .en    (st_q != ST_REST),
        .count (cnt)
    );

    busarb_prio #(.DATA_W(DATA_W), .ID_W(ID_W)) u_prio (
        .data        (bus_data_i),
        .own_id      (own_id_i),
        .higher_seen (higher_seen)
    );

    busarb_drive #(.DATA_W(DATA_W), .ID_W(ID_W)) u_drive (
        .st       (st_q),
        .own_id   (own_id_i),
        .tgt_id   (tgt_q),
        .resel    (resel_q),
        .drv_bsy  (drv_bsy_o),
        .drv_sel  (drv_sel_o),
        .drv_io   (drv_io_o),
        .drv_data (drv_data_o)
    );

    always_comb begin
        st_d  = st_q;
        flg_d = '0;
        if (bus_rst_i) begin
            st_d = ST_REST;
        end else begin
            case (st_q)
                ST_REST: begin
                    if (start_i) st_d = ST_ENTRY;
                end
                ST_ENTRY: begin
                    if (bus_quiet && cnt == ENTRY_LAST) st_d = ST_ARB;
                end
                ST_ARB: begin
                    if (cnt == ARB_LAST) begin
                        if (higher_seen) begin
                            flg_d.lost = 1'b1;
                            st_d       = ST_REST;
                        end else begin
                            flg_d.won  = 1'b1;
                            st_d       = ST_SEL;
                        end
                    end
                end
                ST_SEL: begin
                    if (bus_bsy_i) begin
                        flg_d.selected = 1'b1;
                        st_d           = ST_REST;
                    end else if (cnt == RESP_LAST) begin
                        flg_d.timeout  = 1'b1;
                        st_d           = ST_REST;
                    end
                end
                default: st_d = ST_REST;
            endcase
        end
        cnt_clr = (st_d != st_q) || (st_q == ST_ENTRY && !bus_quiet);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_REST;
            flg_q   <= '0;
            tgt_q   <= '0;
            resel_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            flg_q <= flg_d;
            if (st_q == ST_REST && start_i && !bus_rst_i) begin
                tgt_q   <= tgt_id_i;
                resel_q <= resel_i;
            end
        end
    end

    assign won_o      = flg_q.won;
    assign lost_o     = flg_q.lost;
    assign selected_o = flg_q.selected;
    assign timeout_o  = flg_q.timeout;

    // R2: arbitration drive only rises after an idle sample
    a_r2_entry_idle: assert property (@(posedge clk) disable iff (rst)
        ($rose(drv_bsy_o) && !drv_sel_o) |-> $past(!bus_bsy_i && !bus_sel_i));

    // R3: arbitration drives a single ID line
    a_r3_single_id: assert property (@(posedge clk) disable iff (rst)
        (drv_bsy_o && !drv_sel_o) |-> ($countones(drv_data_o) == 1));

    // R4: results are mutually exclusive
    a_r4_flags_excl: assert property (@(posedge clk) disable iff (rst)
        $onehot0({won_o, lost_o, selected_o, timeout_o}));

    // R5: a win is accompanied by selection drive with BSY released
    a_r5_won_selects: assert property (@(posedge clk) disable iff (rst)
        won_o |-> (drv_sel_o && !drv_bsy_o));

    // R6: selected only after BSY was seen
    a_r6_selected_bsy: assert property (@(posedge clk) disable iff (rst)
        selected_o |-> $past(bus_bsy_i));

    // R7: timeout only when no BSY was seen
    a_r7_timeout_quiet: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> !$past(bus_bsy_i));

    // R8: bus reset releases everything and suppresses results
    a_r8_rst_release: assert property (@(posedge clk) disable iff (rst)
        bus_rst_i |=> (!drv_bsy_o && !drv_sel_o && !drv_io_o && drv_data_o == '0
                       && !won_o && !lost_o && !selected_o && !timeout_o));

endmodule

// File: tb/busarb_ctrl_tb_top.sv
`timescale 1ns/1ps
module busarb_ctrl_tb_top;

    localparam int DW = 8;

    typedef struct {
        logic [3:0] code;   // {timeout, selected, lost, won}
        int         cyc;
        string      req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          other_bsy = 1'b0;
    logic          other_sel = 1'b0;
    logic [DW-1:0] other_data = '0;
    logic          bus_rst = 1'b0;
    logic [2:0]    own_id = '0;
    logic [2:0]    tgt_id = '0;
    logic          resel = 1'b0;
    logic          start = 1'b0;

    logic          drv_bsy, drv_sel, drv_io;
    logic [DW-1:0] drv_data;
    logic          won, lost, selected, timeout;

    logic          bus_bsy, bus_sel;
    logic [DW-1:0] bus_data;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t q[$];

    // wired-OR bus model
    assign bus_bsy  = drv_bsy | other_bsy;
    assign bus_sel  = drv_sel | other_sel;
    assign bus_data = drv_data | other_data;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    busarb_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_bsy_i  (bus_bsy),
        .bus_sel_i  (bus_sel),
        .bus_rst_i  (bus_rst),
        .bus_data_i (bus_data),
        .own_id_i   (own_id),
        .tgt_id_i   (tgt_id),
        .resel_i    (resel),
        .start_i    (start),
        .drv_bsy_o  (drv_bsy),
        .drv_sel_o  (drv_sel),
        .drv_io_o   (drv_io),
        .drv_data_o (drv_data),
        .won_o      (won),
        .lost_o     (lost),
        .selected_o (selected),
        .timeout_o  (timeout)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    task automatic expect_evt(input logic [3:0] code, input int at_cyc, input string req);
        exp_t e;
        e.code = code;
        e.cyc  = at_cyc;
        e.req  = req;
        q.push_back(e);
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic kick(input logic [2:0] id, input logic [2:0] tgt,
                        input logic rs, output int c0);
        own_id = id;
        tgt_id = tgt;
        resel  = rs;
        start  = 1'b1;
        c0     = cyc;
        @(negedge clk);
        start  = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [3:0] f;
            f = {timeout, selected, lost, won};
            if (f != 4'b0) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8", "unexpected result flag", int'(f), 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(f == e.code, e.req, "result flag code", int'(f), int'(e.code));
                    check(cyc == e.cyc, e.req, "result flag cycle", cyc, e.cyc);
                end
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(drv_bsy == 0 && drv_sel == 0 && drv_io == 0, "R1", "control drives", int'({drv_bsy, drv_sel, drv_io}), 0);
        check(drv_data == 0, "R1", "data drives", int'(drv_data), 0);
        check({won, lost, selected, timeout} == 0, "R1", "flags", int'({won, lost, selected, timeout}), 0);
        repeat (10) @(negedge clk);

        // Test A: clean win, selection, response
        kick(3'd6, 3'd2, 1'b0, c0);
        expect_evt(4'b0001, c0 + 901, "R4");
        wait_to(c0 + 300);
        check(drv_bsy == 0, "R2", "no drive before entry delay", int'(drv_bsy), 0);
        wait_to(c0 + 301);
        check(drv_bsy == 1, "R3", "arbitration BSY", int'(drv_bsy), 1);
        check(drv_data == 8'h40, "R3", "own ID line", int'(drv_data), 'h40);
        wait_to(c0 + 900);
        check(drv_bsy == 1 && drv_sel == 0, "R3", "held to end of window", int'({drv_bsy, drv_sel}), 2);
        wait_to(c0 + 901);
        check(drv_sel == 1 && drv_bsy == 0, "R5", "SEL up, BSY released", int'({drv_sel, drv_bsy}), 2);
        check(drv_data == 8'h44, "R5", "own and target lines", int'(drv_data), 'h44);
        check(drv_io == 0, "R5", "I/O for selection", int'(drv_io), 0);
        wait_to(c0 + 905);
        other_bsy = 1'b1;
        expect_evt(4'b0100, c0 + 906, "R6");
        wait_to(c0 + 906);
        check(drv_sel == 0 && drv_data == 0, "R6", "drives released", int'({drv_sel, drv_data}), 0);
        other_bsy = 1'b0;
        repeat (20) @(negedge clk);

        // Test B: higher contender -> lost
        kick(3'd3, 3'd0, 1'b0, c0);
        expect_evt(4'b0010, c0 + 901, "R4");
        wait_to(c0 + 310);
        other_bsy  = 1'b1;
        other_data = 8'h20;
        wait_to(c0 + 901);
        check(drv_bsy == 0 && drv_sel == 0 && drv_data == 0, "R4", "drives released on loss",
              int'({drv_bsy, drv_sel, drv_data}), 0);
        other_bsy  = 1'b0;
        other_data = '0;
        repeat (20) @(negedge clk);

        // Test C: lower contender -> win
        kick(3'd3, 3'd5, 1'b0, c0);
        expect_evt(4'b0001, c0 + 901, "R4");
        wait_to(c0 + 310);
        other_bsy  = 1'b1;
        other_data = 8'h02;
        wait_to(c0 + 901);
        check(drv_data == 8'h28 && drv_sel == 1, "R5", "selection lines after win over lower",
              int'({drv_sel, drv_data}), 'h128);
        other_bsy  = 1'b0;
        other_data = '0;
        wait_to(c0 + 920);
        other_bsy = 1'b1;
        expect_evt(4'b0100, c0 + 921, "R6");
        wait_to(c0 + 922);
        other_bsy = 1'b0;
        repeat (20) @(negedge clk);

        // Test D: busy bus restarts entry count, then timeout
        other_bsy = 1'b1;
        kick(3'd6, 3'd1, 1'b0, c0);
        expect_evt(4'b0001, c0 + 950, "R4");
        expect_evt(4'b1000, c0 + 50950, "R7");
        wait_to(c0 + 50);
        other_bsy = 1'b0;
        wait_to(c0 + 349);
        check(drv_bsy == 0, "R2", "count restarted by busy bus", int'(drv_bsy), 0);
        wait_to(c0 + 350);
        check(drv_bsy == 1, "R2", "arbitration after full idle count", int'(drv_bsy), 1);
        wait_to(c0 + 50949);
        check(drv_sel == 1, "R7", "still selecting at last window cycle", int'(drv_sel), 1);
        wait_to(c0 + 50950);
        check(drv_sel == 0 && drv_data == 0, "R7", "drives released on timeout", int'({drv_sel, drv_data}), 0);
        repeat (20) @(negedge clk);

        // Test E: top ID 7 beats 6; reselection; response on final window cycle (R9)
        kick(3'd7, 3'd4, 1'b1, c0);
        expect_evt(4'b0001, c0 + 901, "R9");
        wait_to(c0 + 310);
        other_bsy  = 1'b1;
        other_data = 8'h40;
        wait_to(c0 + 901);
        other_bsy  = 1'b0;
        other_data = '0;
        check(drv_io == 1, "R5", "I/O for reselection", int'(drv_io), 1);
        check(drv_data == 8'h90, "R5", "reselection lines", int'(drv_data), 'h90);
        wait_to(c0 + 50900);
        check(drv_sel == 1, "R7", "window still open", int'(drv_sel), 1);
        other_bsy = 1'b1;
        expect_evt(4'b0100, c0 + 50901, "R7");
        wait_to(c0 + 50901);
        other_bsy = 1'b0;
        repeat (20) @(negedge clk);

        // Test F: bus reset during arbitration cancels request; start ignored
        kick(3'd2, 3'd1, 1'b0, c0);
        wait_to(c0 + 400);
        check(drv_bsy == 1, "R8", "arbitrating before reset", int'(drv_bsy), 1);
        bus_rst = 1'b1;
        start   = 1'b1;
        wait_to(c0 + 401);
        check(drv_bsy == 0 && drv_data == 0, "R8", "drives released by bus reset", int'({drv_bsy, drv_data}), 0);
        wait_to(c0 + 405);
        bus_rst = 1'b0;
        start   = 1'b0;
        wait_to(c0 + 1300);
        check(drv_bsy == 0 && drv_sel == 0, "R8", "request dropped after bus reset", int'({drv_bsy, drv_sel}), 0);

        // Test G: bus reset coincides with response
        kick(3'd5, 3'd3, 1'b0, c0);
        expect_evt(4'b0001, c0 + 901, "R4");
        wait_to(c0 + 905);
        bus_rst   = 1'b1;
        other_bsy = 1'b1;
        wait_to(c0 + 906);
        check(selected == 0, "R8", "no selected flag under reset", int'(selected), 0);
        check(drv_sel == 0 && drv_data == 0, "R8", "released under reset", int'({drv_sel, drv_data}), 0);
        bus_rst   = 1'b0;
        other_bsy = 1'b0;
        repeat (20) @(negedge clk);

        check(q.size() == 0, "R4", "all expected results seen", q.size(), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule